// File: doc/BRIEF.md
# Three-Bank Level Interrupt Controller with Shortcut Mirroring

This block collects level-sensitive interrupt requests from three banks and merges them into one interrupt line for a processor. Bank 0 has 8 local sources; banks 1 and 2 have 32 sources each. Every bank has its own mask, which is programmed through a pair of write-only ports: one sets mask bits and the other clears them. Software reads a pending word per bank, which is the live source level ANDed with that bank's mask. Nothing is latched.

The bank 0 pending word also acts as the top-level status. It carries one summary bit for each of banks 1 and 2. It also mirrors a fixed set of bank 1 and bank 2 sources directly, so that a handler can identify them with a single read. A mirrored source does not raise its bank's summary bit. The summary bits cannot be masked. A mirrored source can be masked only in its own bank. The output line is high whenever any bit of the bank 0 pending word is set.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset all three masks are cleared, so every pending word reads 0 and `irq_out` is low even when every source is high.
- R2: A write to the enable port of a bank sets each mask bit whose data bit is 1 and leaves the other mask bits unchanged. The enable ports are bank 0 at 0x18, bank 1 at 0x10 and bank 2 at 0x14.
- R3: A write to the disable port of a bank clears each mask bit whose data bit is 1 and leaves the other mask bits unchanged. The disable ports are bank 0 at 0x24, bank 1 at 0x1C and bank 2 at 0x20.
- R4: The pending word of a bank equals its source levels ANDed with its mask, combinationally. Bank 1 reads at 0x04 and bank 2 at 0x08. Bank 0 reads at 0x00, and its local sources sit in bits 7:0.
- R5: Bit 8 of the word at 0x00 is 1 when any enabled bank 1 source outside the mirrored set is high. Bit 9 does the same for bank 2. The bank 0 mask has no effect on either bit.
- R6: Bank 1 sources 7, 9, 10, 18 and 19, when enabled and high, appear at bits 10, 11, 12, 13 and 14 of the word at 0x00, respectively. They do not set bit 8.
- R7: Bank 2 sources 21, 22, 23, 24, 25 and 30, when enabled and high, appear at bits 15 to 20 of the word at 0x00, in that order. They do not set bit 9.
- R8: Writes to the bank 0 enable or disable port at bit positions 8 and above have no effect. A mirrored bit is masked only through its own bank's ports.
- R9: Bits 31:21 of the word at 0x00 read 0. Writes to the pending addresses change nothing. Any address that is not a pending address reads 0.
- R10: `irq_out` is the OR of all bits of the word at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_b0 | input | 8 | Bank 0 source levels |
| src_b1 | input | 32 | Bank 1 source levels |
| src_b2 | input | 32 | Bank 2 source levels |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |

## Verification
For each of banks 1 and 2, the bench enables the whole bank and then walks a single high source through all 32 positions. Each position must land either on its own mirror bit or on the bank summary bit, and never on both. This separates a wrong mirror index from a summary that leaks.

Bank 0 is swept one bit at a time under both mask states. All-ones patterns are used with partially set masks to show that set and clear affect only the written bits. A further pattern masks bank 0 fully while bank 1 sources stay high, which shows that the summary and mirror bits ignore the bank 0 mask. All-ones source patterns also expose the constant-zero upper field of the word at 0x00.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int B0_SRC   = 8;
  localparam int BX_SRC   = 32;
  localparam int N_SC1    = 5;
  localparam int N_SC2    = 6;
  localparam int SUM1_POS = B0_SRC;
  localparam int SUM2_POS = B0_SRC + 1;
  localparam int SC1_POS  = B0_SRC + 2;
  localparam int SC2_POS  = SC1_POS + N_SC1;
  localparam int USED_W   = SC2_POS + N_SC2;

  localparam logic [ADDR_W-1:0] A_PEND0 = 6'h00;
  localparam logic [ADDR_W-1:0] A_PEND1 = 6'h04;
  localparam logic [ADDR_W-1:0] A_PEND2 = 6'h08;
  localparam logic [ADDR_W-1:0] A_EN1   = 6'h10;
  localparam logic [ADDR_W-1:0] A_EN2   = 6'h14;
  localparam logic [ADDR_W-1:0] A_EN0   = 6'h18;
  localparam logic [ADDR_W-1:0] A_DIS1  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_DIS2  = 6'h20;
  localparam logic [ADDR_W-1:0] A_DIS0  = 6'h24;

  // Source index in bank 1 of mirror slot k
  function automatic int sc1_src(input int k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  // Source index in bank 2 of mirror slot k
  function automatic int sc2_src(input int k);
    if (k < 5) return 21 + k;
    return 30;
  endfunction

  function automatic logic [BX_SRC-1:0] sc1_set();
    logic [BX_SRC-1:0] m;
    m = '0;
    for (int k = 0; k < N_SC1; k++) m[sc1_src(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [BX_SRC-1:0] sc2_set();
    logic [BX_SRC-1:0] m;
    m = '0;
    for (int k = 0; k < N_SC2; k++) m[sc2_src(k)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irqc_mask_bank.sv
module irqc_mask_bank #(
  parameter int W = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [W-1:0]      mask_q
);
  logic         set_hit;
  logic         clr_hit;
  logic [W-1:0] bits;

  assign set_hit = wr && (addr == SET_ADDR);
  assign clr_hit = wr && (addr == CLR_ADDR);
  assign bits    = wdata[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (set_hit) mask_q <= mask_q | bits;
    else if (clr_hit) mask_q <= mask_q & ~bits;
  end

  a_r2_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((mask_q & $past(bits)) == $past(bits)));
  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> ((mask_q & ~$past(bits)) == ($past(mask_q) & ~$past(bits))));
  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> ((mask_q & $past(bits)) == '0));
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_hit || clr_hit) |=> $stable(mask_q));
endmodule

// File: rtl/irqc_bank0_merge.sv
module irqc_bank0_merge
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [B0_SRC-1:0] loc_pend,
  input  logic [BX_SRC-1:0] pend1,
  input  logic [BX_SRC-1:0] pend2,
  output logic [DATA_W-1:0] word
);
  localparam logic [BX_SRC-1:0] SC1_M = sc1_set();
  localparam logic [BX_SRC-1:0] SC2_M = sc2_set();

  logic [N_SC1-1:0] mir1;
  logic [N_SC2-1:0] mir2;
  logic             sum1;
  logic             sum2;

  for (genvar k = 0; k < N_SC1; k++) begin : g_mir1
    assign mir1[k] = pend1[sc1_src(k)];
  end
  for (genvar k = 0; k < N_SC2; k++) begin : g_mir2
    assign mir2[k] = pend2[sc2_src(k)];
  end

  assign sum1 = |(pend1 & ~SC1_M);
  assign sum2 = |(pend2 & ~SC2_M);
  assign word = {{(DATA_W-USED_W){1'b0}}, mir2, mir1, sum2, sum1, loc_pend};

  a_r6_mirror_no_summary: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend1 != '0) && ((pend1 & SC1_M) == pend1)) |-> !word[SUM1_POS]);
  a_r7_mirror_no_summary: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend2 != '0) && ((pend2 & SC2_M) == pend2)) |-> !word[SUM2_POS]);
  a_r5_summary_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend1 & ~SC1_M) != '0) |-> word[SUM1_POS]);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [B0_SRC-1:0] src_b0,
  input  logic [BX_SRC-1:0] src_b1,
  input  logic [BX_SRC-1:0] src_b2,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic [B0_SRC-1:0] mask0;
  logic [BX_SRC-1:0] mask1;
  logic [BX_SRC-1:0] mask2;
  logic [BX_SRC-1:0] pend1;
  logic [BX_SRC-1:0] pend2;
  logic [B0_SRC-1:0] loc_pend;
  logic [DATA_W-1:0] top_word;

  irqc_mask_bank #(.W(B0_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .SET_ADDR(A_EN0), .CLR_ADDR(A_DIS0)) u_mask0 (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mask_q(mask0));
  irqc_mask_bank #(.W(BX_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .SET_ADDR(A_EN1), .CLR_ADDR(A_DIS1)) u_mask1 (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mask_q(mask1));
  irqc_mask_bank #(.W(BX_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                   .SET_ADDR(A_EN2), .CLR_ADDR(A_DIS2)) u_mask2 (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .mask_q(mask2));

  assign loc_pend = src_b0 & mask0;
  assign pend1    = src_b1 & mask1;
  assign pend2    = src_b2 & mask2;

  irqc_bank0_merge u_merge (
    .clk(clk), .rst_n(rst_n), .loc_pend(loc_pend),
    .pend1(pend1), .pend2(pend2), .word(top_word));

  assign irq_out = |top_word;

  always_comb begin
    case (bus_addr)
      A_PEND0: bus_rdata = top_word;
      A_PEND1: bus_rdata = pend1;
      A_PEND2: bus_rdata = pend2;
      default: bus_rdata = '0;
    endcase
  end

  a_r10_local_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_b0 & mask0) != '0) |-> irq_out);
  a_r10_bank1_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_b1 & mask1) != '0) |-> irq_out);
  a_r4_bank2_drives_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_b2 & mask2) != '0) |-> irq_out);
endmodule

// File: tb/banked_irq_ctrl_bench.sv
module banked_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_b0 = '0;
  logic [31:0] src_b1 = '0;
  logic [31:0] src_b2 = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_irq_ctrl u_banked_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_b0(src_b0), .src_b1(src_b1), .src_b2(src_b2),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  function automatic logic [31:0] exp_top(input logic [7:0] p0,
                                          input logic [31:0] p1,
                                          input logic [31:0] p2);
    int m1[5] = '{7, 9, 10, 18, 19};
    int m2[6] = '{21, 22, 23, 24, 25, 30};
    logic [31:0] r;
    logic [31:0] rest1;
    logic [31:0] rest2;
    r = {24'h0, p0};
    rest1 = p1;
    rest2 = p2;
    for (int k = 0; k < 5; k++) begin
      r[10 + k] = p1[m1[k]];
      rest1[m1[k]] = 1'b0;
    end
    for (int k = 0; k < 6; k++) begin
      r[15 + k] = p2[m2[k]];
      rest2[m2[k]] = 1'b0;
    end
    r[8] = |rest1;
    r[9] = |rest2;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    src_b0 = 8'hFF; src_b1 = '1; src_b2 = '1;
    rst_n = 1'b1;
    // R1: reset state
    rd(6'h00, d); check("R1 pend0", d, 32'h0);
    rd(6'h04, d); check("R1 pend1", d, 32'h0);
    rd(6'h08, d); check("R1 pend2", d, 32'h0);
    check("R1 irq", {31'h0, irq_out}, 32'h0);

    // R2: set semantics
    wr(6'h10, 32'h0);
    rd(6'h04, d); check("R2 zero write", d, 32'h0);
    wr(6'h10, 32'h0000_0081);
    rd(6'h04, d); check("R2 set", d, 32'h0000_0081);
    wr(6'h10, 32'h0000_0100);
    rd(6'h04, d); check("R2 accumulate", d, 32'h0000_0181);
    // R3: clear semantics
    wr(6'h1C, 32'h0000_0001);
    rd(6'h04, d); check("R3 clear", d, 32'h0000_0180);
    wr(6'h1C, 32'h0);
    rd(6'h04, d); check("R3 zero clear", d, 32'h0000_0180);
    wr(6'h14, 32'hF000_000F);
    wr(6'h20, 32'h3000_0003);
    rd(6'h08, d); check("R3 bank2", d, 32'hC000_000C);
    wr(6'h1C, '1);
    wr(6'h20, '1);

    // R9: upper zero with everything enabled
    wr(6'h10, '1); wr(6'h14, '1); wr(6'h18, '1);
    rd(6'h00, d); check("R9 full word", d, 32'h001F_FFFF);
    check("R10 irq all", {31'h0, irq_out}, 32'h1);
    rd(6'h0C, d); check("R9 hole", d, 32'h0);
    rd(6'h3C, d); check("R9 top addr", d, 32'h0);
    rd(6'h10, d); check("R9 enable port read", d, 32'h0);
    wr(6'h00, '1); wr(6'h04, '1);
    src_b0 = '0; src_b1 = '0; src_b2 = '0;
    rd(6'h00, d); check("R9 pend readonly", d, 32'h0);
    check("R10 irq idle", {31'h0, irq_out}, 32'h0);

    // R4 R10: bank 0 sweep
    for (int i = 0; i < 8; i++) begin
      src_b0 = 8'(1 << i);
      rd(6'h00, d); check("R4 bank0 bit", d, exp_top(src_b0, '0, '0));
      check("R10 irq bank0", {31'h0, irq_out}, 32'h1);
    end
    wr(6'h24, 32'h0000_00FF);
    for (int i = 0; i < 8; i++) begin
      src_b0 = 8'(1 << i);
      rd(6'h00, d); check("R4 bank0 masked", d, 32'h0);
      check("R10 irq masked", {31'h0, irq_out}, 32'h0);
    end
    src_b0 = '0;

    // R5 R6: bank 1 walk
    for (int i = 0; i < 32; i++) begin
      src_b1 = 32'(1) << i;
      rd(6'h04, d); check("R4 bank1 pend", d, src_b1);
      rd(6'h00, d); check("R6 bank1 top", d, exp_top('0, src_b1, '0));
    end
    src_b1 = '0;
    // R5 R7: bank 2 walk
    for (int i = 0; i < 32; i++) begin
      src_b2 = 32'(1) << i;
      rd(6'h08, d); check("R4 bank2 pend", d, src_b2);
      rd(6'h00, d); check("R7 bank2 top", d, exp_top('0, '0, src_b2));
    end
    src_b2 = '0;

    // R8: bank 0 mask ports cannot touch mirror or summary bits
    src_b1 = 32'h0000_0081;
    wr(6'h24, 32'hFFFF_FFFF);
    rd(6'h00, d); check("R8 bank0 disable ignored", d, 32'h0000_0500);
    wr(6'h1C, 32'h0000_0080);
    rd(6'h00, d); check("R8 own-bank mask", d, 32'h0000_0100);
    wr(6'h1C, 32'h0000_0001);
    rd(6'h00, d); check("R5 summary off", d, 32'h0);
    check("R10 irq off", {31'h0, irq_out}, 32'h0);
    wr(6'h18, 32'hFFFF_FF00);
    rd(6'h00, d); check("R8 bank0 enable ignored", d, 32'h0);
    src_b0 = 8'hFF;
    rd(6'h00, d); check("R8 high bits did not enable", d, 32'h0);
    src_b2 = 32'h4000_0001;
    rd(6'h00, d); check("R7 mirror and summary", d, 32'h0010_0200);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule